// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

This block is an eight-pin general-purpose I/O port that sits on an APB-style register bus. It holds a direction byte and an output data byte. It drives an output-enable vector and an output-value vector to the pads, and it samples the pad input vector through a synchroniser. Several instances can be placed side by side to serve wider pin groups.

The data register answers to a whole 1 KiB window at the bottom of the map. Address bits [9:2] of each access form a per-pin mask. A write changes only the pins whose mask bit is 1. A read returns 0 on every pin whose mask bit is 0. This lets software set or clear one pin with a single store and test one pin with a single load, with no read-modify-write. The direction register is an ordinary byte at offset 0x400. Every transfer completes in the APB access phase with no wait state and no error response.

Top module: `gpio_mask_port`

## Requirements
- R1: While reset is held and right after it is released, pad_oe and pad_out are 0, the direction byte is 0 (all pins are inputs) and the synchroniser flops are 0.
- R2: A write access (psel=1, penable=1, pwrite=1) to any address with paddr[11:10]=0 loads pwdata[i] into output bit i only where paddr[2+i]=1. Every other output bit keeps its value. The change appears at the clock edge that ends the access.
- R3: In a read access to the data window (paddr[11:10]=0), prdata bit i is 0 wherever paddr[2+i]=0.
- R4: In that read, where the mask bit is 1, a pin whose direction bit is 1 returns its output latch bit, and a pin whose direction bit is 0 returns its synchronised pad bit.
- R5: A change on pad_in shows up in data reads only after two rising clock edges, through a two-stage synchroniser.
- R6: The direction byte is at address 0x400 (paddr[11:2]=0x100). A write loads pwdata[7:0] in full, and a read returns it in prdata[7:0]. Bit value 1 makes a pin an output.
- R7: pad_oe always equals the direction byte, and pad_out always equals the output latch.
- R8: pready is 1 and pslverr is 0 on every cycle, for every address.
- R9: Reads of addresses above 0x400 return 0, and writes to them change neither the direction byte nor the output latch.
- R10: prdata is 0 outside a read access phase, and prdata[31:8] is always 0.
- R11: A setup phase without penable, or a cycle with psel low, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low reset, asynchronous assert |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address; bits [9:2] are the pin mask inside the data window |
| pwdata | input | 32 | Write data; bits [7:0] are used |
| prdata | output | 32 | Read data, valid in the read access phase |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Error response, always low |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |

## Verification
The assertions check on every cycle that a data write takes the written value exactly on the mask bits and leaves the other bits alone. They also check that no register moves without a decoded write, that masked-off bits of a data read are zero, and that the pads follow the registers. The bench's behavioural model shows the things a single-cycle property cannot: the two-edge latency from a pad change to a read, the choice between latch and pad according to direction, and the silence of unmapped addresses and setup-only cycles. It compares the model against the outputs on every clock and adds directed checks at each boundary.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
    localparam int unsigned PIN_COUNT  = 8;
    localparam int unsigned MASK_LSB   = 2;
    localparam int unsigned DIR_OFFSET = 'h400;
    localparam int unsigned WIN_BITS   = MASK_LSB + PIN_COUNT;

    typedef logic [PIN_COUNT-1:0] pin_vec_t;

    typedef struct packed {
        pin_vec_t dir;
        pin_vec_t out;
    } pin_state_t;
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_mask_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic              acc_wr,
    output logic              acc_rd,
    output logic              hit_data,
    output logic              hit_dir,
    output pin_vec_t          mask
);
    localparam int unsigned DIR_WORD = DIR_OFFSET / 4;
    localparam logic [ADDR_W-3:0] DIR_WORD_V = DIR_WORD[ADDR_W-3:0];

    logic access;

    always_comb begin
        access   = psel && penable;
        acc_wr   = access && pwrite;
        acc_rd   = access && !pwrite;
        hit_data = (paddr[ADDR_W-1:WIN_BITS] == '0);
        hit_dir  = (paddr[ADDR_W-1:MASK_LSB] == DIR_WORD_V);
        mask     = paddr[WIN_BITS-1:MASK_LSB];
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_mask_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  pin_vec_t pad_d,
    output pin_vec_t pad_s
);
    pin_vec_t stage_d [STAGES];
    pin_vec_t stage_q [STAGES];

    always_comb begin
        stage_d[0] = pad_d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign pad_s = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
    import gpio_mask_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              hit_data,
    input  logic              hit_dir,
    input  pin_vec_t          mask,
    input  logic [DATA_W-1:0] wdata,
    output pin_vec_t          dir_q,
    output pin_vec_t          out_q
);
    pin_state_t st_d, st_q;
    pin_vec_t   wbyte;
    logic       data_wr, dir_wr;

    always_comb begin
        wbyte   = wdata[PIN_COUNT-1:0];
        data_wr = acc_wr && hit_data;
        dir_wr  = acc_wr && hit_dir;
        st_d    = st_q;
        if (data_wr) st_d.out = (st_q.out & ~mask) | (wbyte & mask);
        if (dir_wr)  st_d.dir = wbyte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_q = st_q.dir;
    assign out_q = st_q.out;

    assert_mask_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && hit_data) |=> ((out_q & $past(mask)) == ($past(wdata[PIN_COUNT-1:0]) & $past(mask))));

    assert_mask_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && hit_data) |=> ((out_q & ~$past(mask)) == ($past(out_q) & ~$past(mask))));

    assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && hit_data) |=> $stable(out_q));

    assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && hit_dir) |=> $stable(dir_q));

    assert_dir_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && hit_dir) |=> (dir_q == $past(wdata[PIN_COUNT-1:0])));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_mask_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              acc_rd,
    input  logic              hit_data,
    input  logic              hit_dir,
    input  pin_vec_t          mask,
    input  pin_vec_t          dir_q,
    input  pin_vec_t          out_q,
    input  pin_vec_t          pad_s,
    output logic [DATA_W-1:0] rdata
);
    pin_vec_t level;
    pin_vec_t sel;

    always_comb begin
        level = (dir_q & out_q) | (~dir_q & pad_s);
        sel   = '0;
        if (acc_rd) begin
            if (hit_data)     sel = level & mask;
            else if (hit_dir) sel = dir_q;
        end
        rdata = '0;
        rdata[PIN_COUNT-1:0] = sel;
    end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_mask_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [7:0]        pad_in,
    output logic [7:0]        pad_oe,
    output logic [7:0]        pad_out
);
    logic     acc_wr, acc_rd, hit_data, hit_dir;
    pin_vec_t mask, dir_q, out_q, pad_s;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .hit_data(hit_data),
        .hit_dir(hit_dir), .mask(mask)
    );

    gpio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(pclk), .rst_n(presetn), .pad_d(pad_in), .pad_s(pad_s)
    );

    gpio_pin_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(pclk), .rst_n(presetn), .acc_wr(acc_wr), .hit_data(hit_data),
        .hit_dir(hit_dir), .mask(mask), .wdata(pwdata),
        .dir_q(dir_q), .out_q(out_q)
    );

    gpio_read_mux #(.DATA_W(DATA_W)) u_rmux (
        .acc_rd(acc_rd), .hit_data(hit_data), .hit_dir(hit_dir), .mask(mask),
        .dir_q(dir_q), .out_q(out_q), .pad_s(pad_s), .rdata(prdata)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign pad_oe  = dir_q;
    assign pad_out = out_q;

    assert_rd_masked_R3: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pwrite && paddr[ADDR_W-1:WIN_BITS] == '0)
            |-> ((prdata[PIN_COUNT-1:0] & ~paddr[WIN_BITS-1:MASK_LSB]) == '0));

    assert_rd_idle_R10: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable) |-> (prdata == '0));

    assert_rd_out_pin_R4: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pwrite && paddr[ADDR_W-1:WIN_BITS] == '0)
            |-> ((prdata[PIN_COUNT-1:0] & pad_oe & paddr[WIN_BITS-1:MASK_LSB])
                 == (pad_out & pad_oe & paddr[WIN_BITS-1:MASK_LSB])));
endmodule

// File: tb/gpio_mask_port_test.sv
module gpio_mask_port_test;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_oe, pad_out;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int ref_dir = 0, ref_out = 0, ref_s1 = 0, ref_s2 = 0;

    gpio_mask_port uut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    always #4 pclk = ~pclk;

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // model updates at the same edges as the registers
    always @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            ref_dir = 0; ref_out = 0; ref_s1 = 0; ref_s2 = 0;
        end else begin
            int m;
            m = (paddr >> 2) & 'hFF;
            if (psel && penable && pwrite) begin
                if (paddr < 'h400)
                    ref_out = (ref_out & ~m & 'hFF) | (pwdata & m);
                else if (paddr >= 'h400 && paddr <= 'h403)
                    ref_dir = pwdata & 'hFF;
            end
            ref_s2 = ref_s1;
            ref_s1 = pad_in;
        end
    end

    function automatic int exp_rd();
        int m, lvl;
        m = (paddr >> 2) & 'hFF;
        if (!(psel && penable && !pwrite)) return 0;
        if (paddr < 'h400) begin
            lvl = (ref_dir & ref_out) | (~ref_dir & ref_s2 & 'hFF);
            return lvl & m;
        end
        if (paddr <= 'h403) return ref_dir;
        return 0;
    endfunction

    // per-clock comparison against the model, away from the edge
    always @(negedge pclk) begin
        #2;
        if (presetn) begin
            check("R7 pad_oe", pad_oe, ref_dir);
            check("R7 pad_out", pad_out, ref_out);
            check("R8 ready/err", {pready, pslverr}, 2'b10);
            check("R3/R4/R9/R10 prdata", prdata, exp_rd());
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        #1 check("R10 setup-phase prdata", prdata, 0);
        @(negedge pclk);
        penable = 1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    initial begin : watchdog
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        #1 check("R1 pad_oe in reset", pad_oe, 0);
        check("R1 pad_out in reset", pad_out, 0);
        repeat (3) @(negedge pclk);
        presetn = 1;
        @(negedge pclk); #1;
        check("R1 pad_oe after reset", pad_oe, 0);
        check("R1 pad_out after reset", pad_out, 0);
        bus_read(12'h400, rd);
        check("R1 dir after reset", rd, 0);

        // R6 full direction byte
        bus_write(12'h400, 32'hFFFF_FF5A);
        bus_read(12'h400, rd);
        check("R6 dir readback", rd, 32'h5A);
        bus_write(12'h400, 32'hFF);
        check("R6 pad_oe all out", pad_oe, 8'hFF);

        // R2 masked writes
        bus_write(12'h3FC, 32'hAA);
        check("R2 full-mask write", pad_out, 8'hAA);
        bus_write(12'h008, 32'h00);
        check("R2 single-bit clear", pad_out, 8'hA8);
        bus_write(12'h000, 32'hFF);
        check("R2 zero mask no change", pad_out, 8'hA8);
        bus_write(12'h144, 32'hFF);
        check("R2 mask 0x51 set", pad_out, 8'hF9);

        // R3 masked read of output pins
        bus_read(12'h03C, rd);
        check("R3 masked read", rd, 32'h09);

        // R4 mixed directions
        bus_write(12'h400, 32'h0F);
        pad_in = 8'h50;
        repeat (3) @(negedge pclk);
        bus_read(12'h3FC, rd);
        check("R4 mixed read", rd, 32'h59);

        // R5 synchroniser latency on input pins (dir low nibble out)
        @(negedge pclk);
        psel = 1; penable = 1; pwrite = 0; paddr = 12'h3C0; pad_in = 8'hA0;
        #1 check("R5 zero edges", rd_now(), 32'h50);
        @(negedge pclk); #1 check("R5 one edge", rd_now(), 32'h50);
        @(negedge pclk); #1 check("R5 two edges", rd_now(), 32'hA0);
        psel = 0; penable = 0;

        // R9 unmapped
        bus_write(12'h800, 32'h00);
        bus_write(12'h404, 32'h00);
        check("R9 dir kept", pad_oe, 8'h0F);
        check("R9 out kept", pad_out, 8'hF9);
        bus_read(12'hFFC, rd);
        check("R9 unmapped read", rd, 0);

        // R11 setup-only and unselected cycles
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 1; paddr = 12'h400; pwdata = 32'h00;
        @(negedge pclk);
        psel = 0; penable = 1;
        @(negedge pclk);
        penable = 0; pwrite = 0;
        @(negedge pclk); #1;
        check("R11 dir after setup-only", pad_oe, 8'h0F);

        // R10 upper bits zero with all-ones write
        bus_write(12'h400, 32'hFFFF_FFFF);
        bus_read(12'h400, rd);
        check("R10 upper bits", rd, 32'hFF);

        repeat (4) @(negedge pclk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [31:0] rd_now();
        return prdata;
    endfunction
endmodule